// File: doc/BRIEF.md
# Supply Power-Good and Reset Logic

This block turns per-rail supply status into one board-level "healthy" indication and a local reset for downstream logic. It watches four rails (+12V, +5V, +3.3V and -12V). For each rail it receives a digitized undervoltage flag from an external comparator and a status bit that says the rail's external pass switch is on. It also receives a three-state configuration code and an active-low reset from the host bus.

Healthy is asserted on the first clock edge at which every rail that counts is above threshold and its switch is on. Healthy is dropped at once when a counted switch turns off. An undervoltage on a counted rail drops healthy only after the condition has lasted a full deglitch window, which is 15 µs by default and is counted in clock cycles from a clock-frequency parameter. Any recovery before the window ends restarts the count. The configuration code can exclude the -12V rail. One of its values also selects the 3.3V comparison level for the +5V rail's comparator through a dedicated output. The local reset is held low whenever healthy is not asserted or the bus reset is low.

Top module: `pwrgood_reset_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registered outputs go to `healthy_n`=1, `local_rst_n`=0 and `alt_level_sel`=0 at that edge.
- R2: `healthy_n` goes to 0 at the first clock edge at which every counted rail has its undervoltage flag at 0 and its switch-on bit at 1. It never goes from 1 to 0 while any counted rail is under voltage.
- R3: If any counted switch-on bit is 0 at a clock edge, `healthy_n` is 1 after that edge, with no deglitch delay.
- R4: While healthy is asserted and all counted switches are on, a counted undervoltage flag held high keeps `healthy_n` at 0 for the first DG_CYC-1 edges. `healthy_n` goes to 1 at the DG_CYC-th consecutive edge. DG_CYC = CLK_HZ/1e6 × DEGLITCH_US, which is 3750 at the defaults (250 MHz, 15 µs).
- R5: An edge at which all counted rails are good restarts the deglitch count. A dip shorter than DG_CYC edges, however often it repeats, never deasserts healthy.
- R6: `local_rst_n` after an edge equals 1 only if healthy is asserted after that edge and `bus_rst_n` was 1 at that edge. Otherwise it is 0.
- R7: Codes 2'b00 and 2'b11 of `cfg_mode` count all four rails. Bit index 0 is +12V, 1 is +5V, 2 is +3.3V and 3 is -12V in `rail_uv` and `fet_on`.
- R8: Code 2'b01 excludes rail index 3 from the checks. Its undervoltage flag and switch-on bit then have no effect on `healthy_n`.
- R9: Code 2'b10 also excludes rail index 3, and it drives `alt_level_sel` to 1 after the next edge. Every other code drives it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Supply configuration code |
| rail_uv | input | 4 | Per-rail undervoltage flag, 1 = below threshold |
| fet_on | input | 4 | Per-rail pass-switch on status, 1 = on |
| bus_rst_n | input | 1 | Incoming active-low bus reset |
| healthy_n | output | 1 | Active-low board-healthy indication |
| local_rst_n | output | 1 | Active-low reset for downstream logic |
| alt_level_sel | output | 1 | Selects the 3.3V comparison level for the +5V rail comparator |

## Verification
A wrong deglitch count shows at `healthy_n` exactly at the DG_CYC-th edge of a sustained undervoltage: either it rises one edge early or late, or it does not rise at all. A count that is not cleared on recovery makes a repeated short dip deassert healthy within a second window. A wrong mask decode for the configuration code shows within one edge, because an ignored -12V flag or switch bit either moves `healthy_n` or fails to move it. `local_rst_n` follows one edge behind its causes, so a wrong gate in its path appears on the first edge after `bus_rst_n` or healthy changes.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    // Supply configuration codes
    typedef enum logic [1:0] {
        CFG_ALL_RAILS = 2'b00,
        CFG_NO_NEG    = 2'b01,
        CFG_ALT_LEVEL = 2'b10,
        CFG_RESERVED  = 2'b11
    } cfg_e;

    // The negative rail is dropped from all checks in these codes
    function automatic logic neg_rail_masked(input cfg_e code);
        return (code == CFG_NO_NEG) || (code == CFG_ALT_LEVEL);
    endfunction

    // The +5V comparator uses its 3.3V level in this code
    function automatic logic alt_level(input cfg_e code);
        return code == CFG_ALT_LEVEL;
    endfunction

    typedef struct packed {
        logic lrst_n;
        logic alt_sel;
    } out_st_t;

endpackage

// File: rtl/pgr_rail_qualify.sv
module pgr_rail_qualify
    import pgr_pkg::*;
#(
    parameter int N_RAILS = 4,
    parameter int NEG_IDX = 3
) (
    input  logic [1:0]         cfg_mode,
    input  logic [N_RAILS-1:0] rail_uv,
    input  logic [N_RAILS-1:0] fet_on,
    output logic               all_good,
    output logic               all_on
);
    logic [N_RAILS-1:0] counted;
    logic [N_RAILS-1:0] rail_ok;
    logic [N_RAILS-1:0] sw_ok;
    logic               neg_mask;

    always_comb neg_mask = neg_rail_masked(cfg_e'(cfg_mode));

    for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
        if (i == NEG_IDX) begin : g_neg
            always_comb counted[i] = !neg_mask;
        end else begin : g_pos
            always_comb counted[i] = 1'b1;
        end
        always_comb begin
            rail_ok[i] = !counted[i] || !rail_uv[i];
            sw_ok[i]   = !counted[i] || fet_on[i];
        end
    end

    always_comb begin
        all_good = &rail_ok;
        all_on   = &sw_ok;
    end

    // R8: a masked negative rail never blocks the good indication
    always_comb begin
        if (neg_mask && (rail_uv[NEG_IDX-1:0] == '0) && (fet_on[NEG_IDX-1:0] == '1))
            a_mask_neg_r8: assert (all_good && all_on);
    end
endmodule

// File: rtl/pgr_deglitch.sv
module pgr_deglitch #(
    parameter int unsigned DG_CYC = 3750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_good,
    input  logic all_on,
    output logic healthy,
    output logic healthy_nxt
);
    localparam int unsigned CW = (DG_CYC < 2) ? 1 : $clog2(DG_CYC);
    localparam logic [CW-1:0] LAST = CW'(DG_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          good;
    } dg_st_t;

    dg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!all_on) begin
            // switch off: drop at once
            st_d.good = 1'b0;
            st_d.cnt  = '0;
        end else if (all_good) begin
            st_d.good = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.good) begin
            if (st_q.cnt == LAST) begin
                st_d.good = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        healthy     = st_q.good;
        healthy_nxt = rst_n && st_d.good;
    end

    p_fet_off_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !all_on |=> !st_q.good);
    p_fast_assert_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (all_on && all_good) |=> st_q.good);
    p_no_assert_bad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.good && !all_good) |=> !st_q.good);
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    p_good_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        all_good |=> (st_q.cnt == '0));
endmodule

// File: rtl/pwrgood_reset_ctrl.sv
module pwrgood_reset_ctrl
    import pgr_pkg::*;
#(
    parameter int N_RAILS     = 4,
    parameter int NEG_IDX     = 3,
    parameter int CLK_HZ      = 250_000_000,
    parameter int DEGLITCH_US = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic [N_RAILS-1:0] rail_uv,
    input  logic [N_RAILS-1:0] fet_on,
    input  logic               bus_rst_n,
    output logic               healthy_n,
    output logic               local_rst_n,
    output logic               alt_level_sel
);
    localparam int unsigned DG_CYC = (CLK_HZ / 1_000_000) * DEGLITCH_US;

    logic    all_good, all_on;
    logic    healthy, healthy_nxt;
    out_st_t out_d, out_q;

    pgr_rail_qualify #(
        .N_RAILS(N_RAILS),
        .NEG_IDX(NEG_IDX)
    ) i_qualify (
        .cfg_mode(cfg_mode),
        .rail_uv (rail_uv),
        .fet_on  (fet_on),
        .all_good(all_good),
        .all_on  (all_on)
    );

    pgr_deglitch #(
        .DG_CYC(DG_CYC)
    ) i_deglitch (
        .clk        (clk),
        .rst_n      (rst_n),
        .all_good   (all_good),
        .all_on     (all_on),
        .healthy    (healthy),
        .healthy_nxt(healthy_nxt)
    );

    always_comb begin
        out_d         = out_q;
        out_d.lrst_n  = healthy_nxt && bus_rst_n;
        out_d.alt_sel = alt_level(cfg_e'(cfg_mode));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        healthy_n     = !healthy;
        local_rst_n   = out_q.lrst_n;
        alt_level_sel = out_q.alt_sel;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (healthy_n && !local_rst_n && !alt_level_sel));
    p_bus_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> !local_rst_n);
    p_unhealthy_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        healthy_n |-> !local_rst_n);
    p_alt_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b10) |=> alt_level_sel);
endmodule

// File: tb/test_pwrgood_reset_ctrl.sv
module test_pwrgood_reset_ctrl;
    localparam int DG = 250 * 15;  // cycles in the 15 us window at 250 MHz

    typedef struct packed {
        logic [1:0] cfg;
        logic [3:0] uv;
        logic [3:0] fet;
        logic       bus;
        logic       h_n;
        logic       lr_n;
        logic       alt;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{2'b00, 4'b0000, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2}, // R2 all good
        '{2'b00, 4'b0000, 4'b0111, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 neg switch off
        '{2'b01, 4'b0000, 4'b0111, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 neg switch masked
        '{2'b01, 4'b1000, 4'b0111, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 neg uv masked
        '{2'b01, 4'b1000, 4'b0111, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 bus reset
        '{2'b10, 4'b1000, 4'b0111, 1'b1, 1'b0, 1'b1, 1'b1, 4'd9}, // R9 alt level
        '{2'b11, 4'b1000, 4'b0111, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 reserved counts neg
        '{2'b11, 4'b1000, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7}, // R7 neg uv blocks
        '{2'b00, 4'b0000, 4'b1111, 1'b1, 1'b0, 1'b1, 1'b0, 4'd2}, // R2 reassert
        '{2'b00, 4'b0000, 4'b1110, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 12V switch off
        '{2'b00, 4'b0010, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 bad rail blocks
        '{2'b10, 4'b0010, 4'b1111, 1'b1, 1'b1, 1'b0, 1'b1, 4'd9}, // R9 5V still counted
        '{2'b10, 4'b0000, 4'b0111, 1'b1, 1'b0, 1'b1, 1'b1, 4'd9}  // R9 neg masked
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [3:0] rail_uv = 4'b0000;
    logic [3:0] fet_on = 4'b0000;
    logic       bus_rst_n = 1'b1;
    logic       healthy_n, local_rst_n, alt_level_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = !clk;

    pwrgood_reset_ctrl i_pwrgood_reset_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode     (cfg_mode),
        .rail_uv      (rail_uv),
        .fet_on       (fet_on),
        .bus_rst_n    (bus_rst_n),
        .healthy_n    (healthy_n),
        .local_rst_n  (local_rst_n),
        .alt_level_sel(alt_level_sel)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic h, input logic lr, input logic a);
        n_chk++;
        if (healthy_n !== h || local_rst_n !== lr || alt_level_sel !== a) begin
            n_bad++;
            $display("FAIL %s: got h_n=%b lr_n=%b alt=%b, expected h_n=%b lr_n=%b alt=%b",
                     req, healthy_n, local_rst_n, alt_level_sel, h, lr, a);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) step();
        check("R1", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cfg_mode  = TBL[i].cfg;
            rail_uv   = TBL[i].uv;
            fet_on    = TBL[i].fet;
            bus_rst_n = TBL[i].bus;
            step();
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].h_n, TBL[i].lr_n, TBL[i].alt);
        end

        // R4: sustained 3.3V undervoltage
        cfg_mode = 2'b00; rail_uv = 4'b0000; fet_on = 4'b1111; bus_rst_n = 1'b1;
        step();
        check("R4 setup", 1'b0, 1'b1, 1'b0);
        rail_uv = 4'b0100;
        repeat (DG - 1) step();
        check("R4 before window end", 1'b0, 1'b1, 1'b0);
        step();
        check("R4 at window end", 1'b1, 1'b0, 1'b0);
        step();
        check("R4 stays low", 1'b1, 1'b0, 1'b0);

        // R5: dips shorter than the window
        rail_uv = 4'b0000;
        step();
        check("R5 recover", 1'b0, 1'b1, 1'b0);
        rail_uv = 4'b0001;
        repeat (DG - 1) step();
        rail_uv = 4'b0000;
        step();
        check("R5 first dip", 1'b0, 1'b1, 1'b0);
        rail_uv = 4'b0001;
        repeat (DG - 1) step();
        check("R5 second dip", 1'b0, 1'b1, 1'b0);
        rail_uv = 4'b0000;
        step();
        check("R5 after dips", 1'b0, 1'b1, 1'b0);

        // R6: bus reset released while healthy
        bus_rst_n = 1'b0;
        step();
        check("R6 bus low", 1'b0, 1'b0, 1'b0);
        bus_rst_n = 1'b1;
        step();
        check("R6 bus high", 1'b0, 1'b1, 1'b0);

        // R1: reset while healthy with alt level
        cfg_mode = 2'b10;
        step();
        check("R9 alt set", 1'b0, 1'b1, 1'b1);
        rst_n = 1'b0;
        step();
        check("R1 mid-run", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        step();
        check("R2 after reset", 1'b0, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule